// File: doc/BRIEF.md
# Crypto Subsystem Interrupt and DMA Request Register

This block is one 32-bit control and status word for a crypto subsystem. Five completion sources report to it through single-cycle pulses: a hash/random-number engine, a DES/3DES engine, an AES engine, a transmit FIFO and a receive FIFO. Each pulse is held as a pending flag. A per-source enable lets a pending flag reach the single interrupt line. A privileged read returns the word and clears every pending flag at the same clock edge.

The same word holds the DMA setup for both directions. Each direction has an enable and a 3-bit trigger code. Code 0 means one word, and code k (1..7) means 4·k words. A receive request is raised while the receive FIFO holds at least that many words. A transmit request is raised while the transmit FIFO has at least that much free space. Bus accesses made without the required privilege have no effect on the word. Each such access sets a sticky flag, one for writes and one for reads, and these flags are also cleared by a privileged read.

Top module: `cryptoIrqDmaCtl`

## Requirements
- R1: After reset every stored bit is zero: a privileged read returns 0x0000_0000, and `irqOut`, `rxDmaReq` and `txDmaReq` are low.
- R2: A pulse on `evtIn[i]` sets pending flag i at the next clock edge. The flags are read back at bit 16 (i=0, receive FIFO), bit 17 (i=1, transmit FIFO), bit 20 (i=2, AES), bit 21 (i=3, DES/3DES) and bit 22 (i=4, hash/PRNG).
- R3: A privileged read (`regRdEn` with `privOk`=1) puts the current word on `regRdata` in the same cycle. At that clock edge it clears all pending flags and both privilege flags. A pulse arriving in the same cycle as the read leaves its flag set.
- R4: A privileged write stores only the interrupt enables (bits 8, 9, 12, 13, 14 for sources 0..4) and bits 7:0. Status bits cannot be written. Bits 29:23, 19:18, 15 and 11:10 always read as zero, so writing all ones reads back 0x0000_73FF.
- R5: `irqOut` is high exactly when some pending flag i has its enable bit set.
- R6: A trigger code c decodes to a threshold of 1 word when c=0 and 4·c words otherwise.
- R7: `rxDmaReq` equals bit 0 (receive enable) AND (`rxFillCnt` ≥ threshold of code in bits 3:1).
- R8: `txDmaReq` equals bit 4 (transmit enable) AND (`txFreeCnt` ≥ threshold of code in bits 7:5).
- R9: A write with `privOk`=0 changes no stored field and sets bit 31.
- R10: A read with `privOk`=0 returns zero, clears nothing and sets bit 30.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| privOk | input | 1 | Access carries the required privilege |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data, valid in the read cycle, zero otherwise |
| evtIn | input | 5 | Completion pulses: 0 rx FIFO, 1 tx FIFO, 2 AES, 3 DES, 4 hash |
| rxFillCnt | input | CNT_W | Words held in the receive FIFO |
| txFreeCnt | input | CNT_W | Free words in the transmit FIFO |
| irqOut | output | 1 | Combined enabled interrupt |
| rxDmaReq | output | 1 | Receive DMA request |
| txDmaReq | output | 1 | Transmit DMA request |

## Verification
A read-to-clear and a completion pulse can land in the same cycle, and the pulse must win. The bench issues privileged reads while several sources pulse together. It checks that the returned word still shows the old flags, and that the next read shows the new ones. Unprivileged accesses are also interleaved with pending flags, to show that a rejected read neither returns data nor clears anything.

// File: rtl/cidc_pkg.sv
package cidc_pkg;
  localparam int SRC_NUM = 5;
  localparam int LVL_W   = 3;
  localparam int LVL_STEP = 4;

  typedef struct packed {
    logic [SRC_NUM-1:0] irqEn;
    logic [LVL_W-1:0]   txLvl;
    logic               txEn;
    logic [LVL_W-1:0]   rxLvl;
    logic               rxEn;
  } cfg_t;

  typedef struct packed {
    logic cfgWrite;
    logic rdClear;
    logic wrPrivErr;
    logic rdPrivErr;
  } cidc_stb_t;

  function automatic int statBit(int i);
    case (i)
      0: return 16;
      1: return 17;
      2: return 20;
      3: return 21;
      default: return 22;
    endcase
  endfunction

  function automatic int enBit(int i);
    case (i)
      0: return 8;
      1: return 9;
      2: return 12;
      3: return 13;
      default: return 14;
    endcase
  endfunction

  function automatic logic [31:0] lvlWords(logic [LVL_W-1:0] code);
    if (code == '0) return 32'd1;
    return 32'(code) * LVL_STEP;
  endfunction
endpackage

// File: rtl/cidc_ctrl.sv
module cidc_ctrl
  import cidc_pkg::*;
(
  input  logic      regWrEn,
  input  logic      regRdEn,
  input  logic      privOk,
  output cidc_stb_t stb
);
  always_comb begin
    stb.cfgWrite  = regWrEn && privOk;
    stb.rdClear   = regRdEn && privOk;
    stb.wrPrivErr = regWrEn && !privOk;
    stb.rdPrivErr = regRdEn && !privOk;
  end
endmodule

// File: rtl/cidc_datapath.sv
module cidc_datapath
  import cidc_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  cidc_stb_t          stb,
  input  logic [31:0]        regWdata,
  input  logic [SRC_NUM-1:0] evtIn,
  output cfg_t               cfgQ,
  output logic [SRC_NUM-1:0] pendQ,
  output logic [1:0]         privQ,
  output logic [31:0]        regRdata,
  output logic               irqOut
);
  cfg_t        cfgNext;
  logic [31:0] wordView;

  always_comb begin
    cfgNext.rxEn  = regWdata[0];
    cfgNext.rxLvl = regWdata[3:1];
    cfgNext.txEn  = regWdata[4];
    cfgNext.txLvl = regWdata[7:5];
    for (int i = 0; i < SRC_NUM; i++) cfgNext.irqEn[i] = regWdata[enBit(i)];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgQ  <= '0;
      pendQ <= '0;
      privQ <= '0;
    end else begin
      if (stb.cfgWrite) cfgQ <= cfgNext;
      pendQ    <= (pendQ & ~{SRC_NUM{stb.rdClear}}) | evtIn;
      privQ[1] <= (privQ[1] && !stb.rdClear) || stb.wrPrivErr;
      privQ[0] <= (privQ[0] && !stb.rdClear) || stb.rdPrivErr;
    end
  end

  always_comb begin
    wordView     = '0;
    wordView[31] = privQ[1];
    wordView[30] = privQ[0];
    for (int i = 0; i < SRC_NUM; i++) begin
      wordView[statBit(i)] = pendQ[i];
      wordView[enBit(i)]   = cfgQ.irqEn[i];
    end
    wordView[7:5] = cfgQ.txLvl;
    wordView[4]   = cfgQ.txEn;
    wordView[3:1] = cfgQ.rxLvl;
    wordView[0]   = cfgQ.rxEn;
  end

  assign regRdata = stb.rdClear ? wordView : '0;
  assign irqOut   = |(pendQ & cfgQ.irqEn);
endmodule

// File: rtl/cidc_lvl.sv
module cidc_lvl
  import cidc_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic             en,
  input  logic [LVL_W-1:0] code,
  input  logic [CNT_W-1:0] count,
  output logic             req
);
  logic [31:0] thrWords;
  assign thrWords = lvlWords(code);
  assign req = en && (32'(count) >= thrWords);
endmodule

// File: rtl/cryptoIrqDmaCtl.sv
module cryptoIrqDmaCtl
  import cidc_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic               regRdEn,
  input  logic               privOk,
  input  logic [31:0]        regWdata,
  output logic [31:0]        regRdata,
  input  logic [SRC_NUM-1:0] evtIn,
  input  logic [CNT_W-1:0]   rxFillCnt,
  input  logic [CNT_W-1:0]   txFreeCnt,
  output logic               irqOut,
  output logic               rxDmaReq,
  output logic               txDmaReq
);
  localparam int DIR_NUM = 2;

  cidc_stb_t          stb;
  cfg_t               cfgQ;
  logic [SRC_NUM-1:0] pendQ;
  logic [1:0]         privQ;

  logic [DIR_NUM-1:0]            dirEn;
  logic [DIR_NUM-1:0][LVL_W-1:0] dirCode;
  logic [DIR_NUM-1:0][CNT_W-1:0] dirCnt;
  logic [DIR_NUM-1:0]            dirReq;

  cidc_ctrl u_ctrl (
    .regWrEn(regWrEn), .regRdEn(regRdEn), .privOk(privOk), .stb(stb)
  );

  cidc_datapath u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .regWdata(regWdata), .evtIn(evtIn),
    .cfgQ(cfgQ), .pendQ(pendQ), .privQ(privQ), .regRdata(regRdata), .irqOut(irqOut)
  );

  assign dirEn   = {cfgQ.txEn, cfgQ.rxEn};
  assign dirCode = {cfgQ.txLvl, cfgQ.rxLvl};
  assign dirCnt  = {txFreeCnt, rxFillCnt};

  for (genvar g = 0; g < DIR_NUM; g++) begin : g_dir
    cidc_lvl #(.CNT_W(CNT_W)) u_lvl (
      .en(dirEn[g]), .code(dirCode[g]), .count(dirCnt[g]), .req(dirReq[g])
    );
  end

  assign rxDmaReq = dirReq[0];
  assign txDmaReq = dirReq[1];
endmodule

// File: rtl/cidc_chk.sv
module cidc_chk
  import cidc_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               regWrEn,
  input logic               regRdEn,
  input logic               privOk,
  input logic [SRC_NUM-1:0] evtIn,
  input logic [31:0]        regRdata,
  input logic               irqOut,
  input logic               rxDmaReq,
  input logic               txDmaReq,
  input cfg_t               cfgQ,
  input logic [SRC_NUM-1:0] pendQ,
  input logic [1:0]         privQ
);
  localparam logic [31:0] RSVD_MASK = 32'h3F8C_8C00;

  p_reserved_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
    (regRdata & RSVD_MASK) == '0);

  p_event_latch_r2: assert property (@(posedge clk) disable iff (!rstN)
    (|evtIn) |=> ((pendQ & $past(evtIn)) == $past(evtIn)));

  p_clear_on_read_r3: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && privOk && evtIn == '0) |=> (pendQ == '0 && privQ == 2'b00));

  p_status_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!regRdEn && evtIn == '0) |=> $stable(pendQ));

  p_irq_idle_r5: assert property (@(posedge clk) disable iff (!rstN)
    (pendQ == '0) |-> !irqOut);

  p_rx_off_r7: assert property (@(posedge clk) disable iff (!rstN)
    !cfgQ.rxEn |-> !rxDmaReq);

  p_tx_off_r8: assert property (@(posedge clk) disable iff (!rstN)
    !cfgQ.txEn |-> !txDmaReq);

  p_bad_write_r9: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && !privOk) |=> (privQ[1] && $stable(cfgQ)));

  p_bad_read_data_r10: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && !privOk) |-> regRdata == '0);

  p_bad_read_keep_r10: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && !privOk) |=> (privQ[0] && (pendQ & $past(pendQ)) == $past(pendQ)));
endmodule

bind cryptoIrqDmaCtl cidc_chk u_chk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn), .privOk(privOk),
  .evtIn(evtIn), .regRdata(regRdata), .irqOut(irqOut), .rxDmaReq(rxDmaReq),
  .txDmaReq(txDmaReq), .cfgQ(cfgQ), .pendQ(pendQ), .privQ(privQ)
);

// File: tb/cryptoIrqDmaCtl_tb.sv
`timescale 1ns/1ps
module cryptoIrqDmaCtl_tb;
  localparam int CNT_W = 6;

  logic clk = 0, rstN = 0;
  logic regWrEn = 0, regRdEn = 0, privOk = 0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic [4:0] evtIn = '0;
  logic [CNT_W-1:0] rxFillCnt = '0, txFreeCnt = '0;
  logic irqOut, rxDmaReq, txDmaReq;

  int nRun = 0, nFail = 0;
  bit done = 0;

  logic [31:0] shCfg = '0;
  logic [4:0]  shPend = '0;
  logic [1:0]  shPriv = '0;

  always #2.5 clk = ~clk;

  cryptoIrqDmaCtl #(.CNT_W(CNT_W)) u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn), .privOk(privOk),
    .regWdata(regWdata), .regRdata(regRdata), .evtIn(evtIn), .rxFillCnt(rxFillCnt),
    .txFreeCnt(txFreeCnt), .irqOut(irqOut), .rxDmaReq(rxDmaReq), .txDmaReq(txDmaReq)
  );

  function automatic logic [31:0] expWord();
    logic [31:0] w;
    w = shCfg & 32'h0000_73FF;
    w[31] = shPriv[1];
    w[30] = shPriv[0];
    w[16] = shPend[0];
    w[17] = shPend[1];
    w[20] = shPend[2];
    w[21] = shPend[3];
    w[22] = shPend[4];
    return w;
  endfunction

  function automatic logic [31:0] enWord(logic [4:0] m);
    logic [31:0] w = '0;
    w[8] = m[0]; w[9] = m[1]; w[12] = m[2]; w[13] = m[3]; w[14] = m[4];
    return w;
  endfunction

  function automatic int thr(int code);
    return code == 0 ? 1 : 4 * code;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic busWrite(logic [31:0] d, logic ok);
    @(negedge clk);
    regWrEn = 1; regWdata = d; privOk = ok;
    @(negedge clk);
    regWrEn = 0; privOk = 0;
    if (ok) shCfg = d & 32'h0000_73FF;
    else shPriv[1] = 1'b1;
  endtask

  task automatic busRead(logic ok, logic [4:0] evt, string req);
    @(negedge clk);
    regRdEn = 1; privOk = ok; evtIn = evt;
    #1;
    check(req, regRdata, ok ? expWord() : 32'h0);
    @(negedge clk);
    regRdEn = 0; privOk = 0; evtIn = '0;
    if (ok) begin shPend = evt; shPriv = 2'b00; end
    else begin shPend = shPend | evt; shPriv[0] = 1'b1; end
  endtask

  task automatic pulse(logic [4:0] evt);
    @(negedge clk);
    evtIn = evt;
    @(negedge clk);
    evtIn = '0;
    shPend = shPend | evt;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    rxFillCnt = '1; txFreeCnt = '1;
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1: reset state
    #1;
    check("R1 irq", 32'(irqOut), 0);
    check("R1 rxreq", 32'(rxDmaReq), 0);
    check("R1 txreq", 32'(txDmaReq), 0);
    busRead(1, 0, "R1 word");

    // R4: only config fields store, reserved and status read zero
    busWrite(32'hFFFF_FFFF, 1);
    busRead(1, 0, "R4 all ones");
    check("R4 value", shCfg, 32'h0000_73FF);
    #1 check("R5 no pending", 32'(irqOut), 0);

    // R2: each source latches at its bit
    for (int s = 0; s < 5; s++) begin
      pulse(5'(1 << s));
      #1 check("R5 enabled pend", 32'(irqOut), 1);
      busRead(1, 0, "R2 latch");
      busRead(1, 0, "R3 cleared");
    end

    // R3: pulses colliding with read survive
    pulse(5'b00011);
    busRead(1, 5'b10101, "R3 collide read");
    busRead(1, 0, "R3 collide kept");

    // R5: enable mask sweep per source
    for (int s = 0; s < 5; s++) begin
      for (int m = 0; m < 32; m++) begin
        busWrite(enWord(5'(m)), 1);
        pulse(5'(1 << s));
        #1 check("R5 irq gate", 32'(irqOut), 32'((m >> s) & 1));
        busRead(1, 0, "R5 readback");
        #1 check("R5 after clear", 32'(irqOut), 0);
      end
    end

    // R9: unprivileged write
    busWrite(32'h0000_1234, 1);
    busWrite(32'hFFFF_FFFF, 0);
    busRead(1, 0, "R9 flag and no change");
    busRead(1, 0, "R9 flag cleared");

    // R10: unprivileged read
    pulse(5'b01000);
    busRead(0, 0, "R10 zero data");
    busRead(1, 0, "R10 flag and pend kept");
    busRead(1, 0, "R10 cleared");

    // R6 R7 R8: trigger code and count sweep
    for (int c = 0; c < 8; c++) begin
      busWrite(32'((((7 - c) << 5) | (1 << 4) | (c << 1) | 1)), 1);
      for (int n = 0; n < (1 << CNT_W); n++) begin
        @(negedge clk);
        rxFillCnt = CNT_W'(n); txFreeCnt = CNT_W'(n);
        #1;
        check("R7 R6 rx req", 32'(rxDmaReq), 32'(n >= thr(c)));
        check("R8 R6 tx req", 32'(txDmaReq), 32'(n >= thr(7 - c)));
      end
      busWrite(32'(((7 - c) << 5) | (c << 1)), 0);
      busWrite(32'(((7 - c) << 5) | (c << 1)), 1);
      @(negedge clk);
      rxFillCnt = '1; txFreeCnt = '1;
      #1;
      check("R7 disabled", 32'(rxDmaReq), 0);
      check("R8 disabled", 32'(txDmaReq), 0);
      busRead(1, 0, "R9 sweep flag");
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule